// File: doc/BRIEF.md
# Power-Fail Classifier and Reboot Policy Unit

This unit sits in the always-on domain and watches three supply indications: the main-supply power-good, the regulator power-good and the active-low resume-well reset. Each is resynchronized to the slow always-on clock. When main power-good drops and later comes back, the unit decides what kind of dropout took place. If the resume reset stayed high during the whole dropout, only power-good was lost. The unit latches a sticky failure flag and always requests a reboot. If the resume reset was seen low at any sampled point before power-good came back, the event counts as a full power loss. A software-owned policy bit then decides whether the machine powers back on.

The unit also forms the processor power-good from the two power-good inputs. It blocks wake requests from sleep states while the battery is low. When the battery goes low while the system is running, it raises a level-type SMI request that stays high until it is acknowledged.

Top module: `pwr_fail_monitor`

## Requirements
- R1: `cpu_pg_out` is the AND of `pg_main_in` and `pg_vreg_in`, whichever of the two changes first.
- R2: `pg_main_in`, `rsm_rst_n_in` and `bat_low_in` pass through a `SYNC_STAGES`-flop synchronizer (default 2). A reboot request is a single-cycle pulse on `reboot_req`, high during the cycle after the third rising clock edge that follows the rise of `pg_main_in` (default depth).
- R3: A dropout of main power-good during which the resume reset is never sampled low sets `pg_fail_flag` and requests a reboot, whatever the value of `policy_stay_off`.
- R4: A dropout during which the resume reset is sampled low at any point, up to and including the cycle in which power-good is seen returning, is a full failure. It requests a reboot only when `policy_stay_off` is 0 (1 means stay off), and it leaves `pg_fail_flag` unchanged.
- R5: After the battery-well reset, the first rise of main power-good is handled as a full failure.
- R6: `pg_fail_flag` is sticky. It survives later dropouts, is cleared by a one-cycle high on `flag_clr` (a same-cycle set wins), and is reset only by `rst_bat_n` low. Reset also clears `reboot_req` and `smi_req`.
- R7: `slp_state` encodes S0=0, S3=1, S4=2, S5=3. In any state other than S0, a synchronized high `bat_low_in` forces `wake_req_out` to 0. Otherwise `wake_req_out` follows `wake_req_in`.
- R8: A synchronized rising edge of `bat_low_in` while `slp_state` is S0 sets `smi_req`. A rise in a sleep state does not. `smi_req` holds until `smi_ack` is high for a cycle.
- R9: While main power-good stays high, changes on `pg_vreg_in` or `rsm_rst_n_in` produce no reboot request and do not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Slow always-on clock |
| rst_bat_n | input | 1 | Battery-well reset, active low, asynchronous |
| pg_main_in | input | 1 | Main-supply power-good, asynchronous |
| pg_vreg_in | input | 1 | Regulator power-good |
| rsm_rst_n_in | input | 1 | Resume-well reset, active low, asynchronous |
| policy_stay_off | input | 1 | After-loss policy: 0 power on, 1 stay off |
| flag_clr | input | 1 | Write-one-to-clear strobe for the failure flag |
| bat_low_in | input | 1 | Battery-low indication, asynchronous, active high |
| slp_state | input | 2 | Current sleep state (S0=0, S3=1, S4=2, S5=3) |
| wake_req_in | input | 1 | Incoming wake request |
| smi_ack | input | 1 | Acknowledge that clears the SMI request |
| cpu_pg_out | output | 1 | Processor power-good |
| wake_req_out | output | 1 | Wake request after battery gating |
| reboot_req | output | 1 | One-cycle reboot request pulse |
| pg_fail_flag | output | 1 | Sticky power-good-only failure flag |
| smi_req | output | 1 | SMI request level |

## Verification
The classifier is driven through dropouts in which the resume reset stays high and dropouts in which it pulses low before power-good returns. Each kind is run under both policy values, so that the forced reboot can be told apart from the policy-controlled one, and the flag shows which class was chosen. Some of these dropouts take the regulator power-good down first and bring it back last, which shows that ordering has no effect. Separate patterns toggle the regulator and resume inputs while main power stays good, which tells spurious triggering from a real dropout. Battery-low is raised in S0 and in sleep states to tell the SMI path from the wake-gating path.

// File: rtl/pwr_fail_monitor.sv
module pwr_fail_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_aon,
  input  logic       rst_bat_n,
  input  logic       pg_main_in,
  input  logic       pg_vreg_in,
  input  logic       rsm_rst_n_in,
  input  logic       policy_stay_off,
  input  logic       flag_clr,
  input  logic       bat_low_in,
  input  logic [1:0] slp_state,
  input  logic       wake_req_in,
  input  logic       smi_ack,
  output logic       cpu_pg_out,
  output logic       wake_req_out,
  output logic       reboot_req,
  output logic       pg_fail_flag,
  output logic       smi_req
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] main_sh, rsm_sh, bat_sh;
  logic main_s, rsm_s, bat_s;
  logic main_prev, bat_prev, full_q;
  logic main_rise, full_now, pg_only, boot_now, bat_rise, in_s0;

  always_ff @(posedge clk_aon or negedge rst_bat_n) begin
    if (!rst_bat_n) begin
      main_sh <= '0;
      rsm_sh  <= '0;
      bat_sh  <= '0;
    end else begin
      main_sh <= {main_sh[LAST-1:0], pg_main_in};
      rsm_sh  <= {rsm_sh[LAST-1:0], rsm_rst_n_in};
      bat_sh  <= {bat_sh[LAST-1:0], bat_low_in};
    end
  end

  assign main_s = main_sh[LAST];
  assign rsm_s  = rsm_sh[LAST];
  assign bat_s  = bat_sh[LAST];

  assign cpu_pg_out   = pg_main_in & pg_vreg_in;
  assign in_s0        = (slp_state == 2'd0);
  assign wake_req_out = wake_req_in & ~(bat_s & ~in_s0);

  assign main_rise = main_s & ~main_prev;
  assign full_now  = full_q | ~rsm_s;
  assign pg_only   = main_rise & ~full_now;
  assign boot_now  = main_rise & (~full_now | ~policy_stay_off);
  assign bat_rise  = bat_s & ~bat_prev;

  always_ff @(posedge clk_aon or negedge rst_bat_n) begin
    if (!rst_bat_n) begin
      main_prev    <= 1'b0;
      bat_prev     <= 1'b0;
      full_q       <= 1'b1;
      reboot_req   <= 1'b0;
      pg_fail_flag <= 1'b0;
      smi_req      <= 1'b0;
    end else begin
      main_prev    <= main_s;
      bat_prev     <= bat_s;
      if (!main_s) full_q <= main_prev ? ~rsm_s : full_now;
      else         full_q <= 1'b0;
      reboot_req   <= boot_now;
      pg_fail_flag <= pg_only | (pg_fail_flag & ~flag_clr);
      smi_req      <= (bat_rise & in_s0) | (smi_req & ~smi_ack);
    end
  end

  assert_pulse_single_R2: assert property (@(posedge clk_aon) disable iff (!rst_bat_n)
    reboot_req |=> !reboot_req);

  assert_reboot_on_rise_R2: assert property (@(posedge clk_aon) disable iff (!rst_bat_n)
    reboot_req |-> main_prev);

  assert_flag_with_reboot_R3: assert property (@(posedge clk_aon) disable iff (!rst_bat_n)
    $rose(pg_fail_flag) |-> reboot_req);

  assert_stay_off_only_pg_R4: assert property (@(posedge clk_aon) disable iff (!rst_bat_n)
    (reboot_req && $past(policy_stay_off)) |-> pg_fail_flag);

  assert_clear_works_R6: assert property (@(posedge clk_aon) disable iff (!rst_bat_n)
    flag_clr |=> (!pg_fail_flag || reboot_req));

  assert_smi_holds_R8: assert property (@(posedge clk_aon) disable iff (!rst_bat_n)
    (smi_req && !smi_ack) |=> smi_req);

endmodule

// File: tb/pwr_fail_monitor_test.sv
module pwr_fail_monitor_test;
  logic clk = 1'b0;
  logic rst_bat_n, pg_main, pg_vreg, rsm_n, policy, clr, bat, wake, ack;
  logic [1:0] slp;
  logic cpu_pg, wake_out, reboot, flag, smi;
  int checks = 0, fails = 0, boots = 0;

  always #2.5 clk = ~clk;

  pwr_fail_monitor uut (
    .clk_aon(clk), .rst_bat_n(rst_bat_n), .pg_main_in(pg_main), .pg_vreg_in(pg_vreg),
    .rsm_rst_n_in(rsm_n), .policy_stay_off(policy), .flag_clr(clr), .bat_low_in(bat),
    .slp_state(slp), .wake_req_in(wake), .smi_ack(ack), .cpu_pg_out(cpu_pg),
    .wake_req_out(wake_out), .reboot_req(reboot), .pg_fail_flag(flag), .smi_req(smi));

  always @(negedge clk) if (reboot === 1'b1) boots++;

  // row: {vreg_first, full_fail, policy, exp_reboot, exp_flag}
  localparam logic [4:0] VEC [6] = '{
    5'b00011, 5'b00111, 5'b01010, 5'b01100, 5'b10111, 5'b11100 };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic dropout(input bit full, input bit vreg_first);
    if (vreg_first) begin pg_vreg = 1'b0; cyc(2); end
    pg_main = 1'b0;
    cyc(4);
    if (full) begin rsm_n = 1'b0; cyc(4); rsm_n = 1'b1; cyc(4); end
    pg_main = 1'b1;
    if (vreg_first) begin cyc(1); pg_vreg = 1'b1; end
    cyc(6);
  endtask

  task automatic clear_flag();
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
  endtask

  initial begin
    rst_bat_n = 0; pg_main = 0; pg_vreg = 0; rsm_n = 0; policy = 0; clr = 0;
    bat = 0; wake = 0; ack = 0; slp = 2'd0;
    cyc(2);
    chk("R6 reset flag", flag, 0);
    chk("R6 reset reboot", reboot, 0);
    chk("R6 reset smi", smi, 0);
    chk("R1 reset cpu_pg", cpu_pg, 0);
    rst_bat_n = 1; rsm_n = 1; pg_vreg = 1;
    cyc(3);
    boots = 0;
    pg_main = 1;
    cyc(2);
    chk("R2 no pulse before third edge", reboot, 0);
    cyc(1);
    chk("R2 pulse after third edge", reboot, 1);
    cyc(1);
    chk("R2 pulse one cycle", reboot, 0);
    chk("R5 first power-up reboots", boots, 1);
    chk("R5 first power-up no flag", flag, 0);
    chk("R1 both good", cpu_pg, 1);
    pg_vreg = 0; #1;
    chk("R1 vreg low", cpu_pg, 0);
    pg_vreg = 1; #1;
    chk("R1 vreg back", cpu_pg, 1);
    cyc(1);

    for (int i = 0; i < 6; i++) begin
      policy = VEC[i][2];
      clear_flag();
      boots = 0;
      dropout(VEC[i][3], VEC[i][4]);
      if (VEC[i][3]) begin
        chk($sformatf("R4 row %0d reboot", i), boots, VEC[i][1]);
        chk($sformatf("R4 row %0d flag", i), flag, VEC[i][0]);
      end else begin
        chk($sformatf("R3 row %0d reboot", i), boots, VEC[i][1]);
        chk($sformatf("R3 row %0d flag", i), flag, VEC[i][0]);
      end
      chk($sformatf("R1 row %0d cpu_pg", i), cpu_pg, 1);
    end

    policy = 0; clear_flag();
    dropout(0, 0);
    chk("R6 flag set", flag, 1);
    dropout(1, 0);
    chk("R6 flag sticky over full failure", flag, 1);
    clear_flag();
    chk("R6 flag cleared", flag, 0);

    boots = 0;
    pg_vreg = 0; cyc(4); pg_vreg = 1; cyc(2);
    rsm_n = 0; cyc(4); rsm_n = 1; cyc(6);
    chk("R9 no reboot", boots, 0);
    chk("R9 no flag", flag, 0);

    wake = 1; slp = 2'd1; bat = 1; cyc(3);
    chk("R7 S3 battery low blocks wake", wake_out, 0);
    chk("R8 rise in S3 no smi", smi, 0);
    slp = 2'd2; #1;
    chk("R7 S4 battery low blocks wake", wake_out, 0);
    slp = 2'd0; #1;
    chk("R7 S0 wake passes", wake_out, 1);
    slp = 2'd3; bat = 0; cyc(3);
    chk("R7 S5 no battery low wake passes", wake_out, 1);
    slp = 2'd0; bat = 1; cyc(4);
    chk("R8 smi set in S0", smi, 1);
    cyc(5);
    chk("R8 smi holds", smi, 1);
    ack = 1; cyc(1); ack = 0;
    chk("R8 smi cleared by ack", smi, 0);

    dropout(0, 0);
    chk("R6 flag set before battery reset", flag, 1);
    bat = 0; cyc(3); bat = 1; cyc(4);
    rst_bat_n = 0; cyc(1);
    chk("R6 battery reset clears flag", flag, 0);
    chk("R6 battery reset clears smi", smi, 0);
    rst_bat_n = 1; cyc(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule